// File: doc/BRIEF.md
# ADC Calibration Cycle Sequencer

This block sets the operating mode of a sigma-delta converter channel and runs its automatic calibration cycles. Software writes a 3-bit mode code. The code selects one of four things: stay idle, convert continuously, run a zero-scale (offset) calibration, or run a full-scale (gain) calibration. Each calibration comes in a self variant and a system variant. The modulator and decimation filter sit outside the block. They appear here only as a conversion-done strobe and a result bus.

A calibration always starts at once and abandons any conversion or calibration in progress. During the cycle the sequencer steers the converter input:
- A self zero-scale calibration measures an internal zero.
- A self full-scale calibration measures the internal zero first and then the internal reference.
- A system calibration measures the external pins throughout.

The sequencer counts filter output periods. When the count completes it writes the coefficient into the offset or gain register, pulses a done flag and drops back to idle. Software may load either coefficient register directly, but only while the channel is idle.

The state machine has five states:
- IDLE and CONV.
- OFFSET: one offset stage.
- GAIN_LO: the low stage of a gain calibration.
- GAIN_HI: the high stage of a gain calibration.

Its transitions are:
- A mode write moves any state to IDLE, CONV, OFFSET or GAIN_LO, according to the code.
- OFFSET goes to IDLE when its stage ends.
- GAIN_LO goes to GAIN_HI when its stage ends.
- GAIN_HI goes to IDLE when its stage ends.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset: mode_q reads 000, busy and cal_done are 0, src_sel is 00, offset_q holds OFF_DEFAULT (16'h8000) and gain_q holds GAIN_DEFAULT (16'h5555).
- R2: The mode codes are 000 idle, 001 continuous conversion, 100 self zero-scale, 101 self full-scale, 110 system zero-scale and 111 system full-scale. A written code is visible on mode_q in the cycle after the write. Codes 010 and 011 act as idle and read back as 000.
- R3: One calibration stage lasts 3 conversion-done strobes when chop_en was 0 at the calibration write, and 2 strobes when it was 1. Changing chop_en later does not alter a running cycle.
- R4: A full-scale calibration has two stages, so it takes twice as many strobes. Its gain coefficient is the result of the final strobe of stage two minus the result of the final strobe of stage one, modulo 2^16.
- R5: A zero-scale calibration loads the result of its final strobe into offset_q and leaves gain_q unchanged.
- R6: In the cycle after the final strobe the new coefficient is visible. In that same cycle mode_q reads 000, busy is 0 and cal_done is 1, for exactly one cycle.
- R7: busy is 1 from the cycle after a calibration write until the cycle in which the calibration ends.
- R8: Writing a calibration code during a conversion or a calibration restarts the stage count from zero.
- R9: src_sel encodes the converter input: 00 external pins, 01 internal zero, 10 internal reference. Self zero-scale uses 01. Self full-scale uses 01 in stage one and 10 in stage two. System calibrations, conversion and idle use 00.
- R10: coef_wr_off and coef_wr_gain load coef_wdata only while mode_q reads 000. In any other mode they are ignored.
- R11: Writing 000 or 001 during a calibration abandons it. No coefficient is written and cal_done stays 0.
- R12: Conversion-done strobes in idle or conversion mode leave both coefficients unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code to write |
| chop_en | input | 1 | Chopping enabled; sampled at calibration start |
| conv_done | input | 1 | Filter output strobe, one cycle per conversion period |
| conv_result | input | DW | Filter result valid with conv_done |
| coef_wr_off | input | 1 | Software write to the offset register |
| coef_wr_gain | input | 1 | Software write to the gain register |
| coef_wdata | input | DW | Software coefficient data |
| mode_q | output | 3 | Current mode code |
| src_sel | output | 2 | Converter input source select |
| busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse when a coefficient is captured |
| offset_q | output | DW | Offset coefficient register |
| gain_q | output | DW | Gain coefficient register |

## Verification
The situations hardest to reach from the ports are a calibration interrupted mid-count and the switch between the two stages of a gain cycle.

To reach the first, the stimulus lets a calibration absorb some strobes and then rewrites its code. It then checks that the full strobe count is needed again, with no capture and no done pulse in between.

For the second, the stimulus feeds a distinct result on every strobe. The captured gain can therefore only match if the difference is taken between exactly the right pair of strobes. A stray done pulse is caught because the scoreboard has no expected item queued for it.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_OFFSET,
        ST_GAIN_LO,
        ST_GAIN_HI
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'b00,
        SRC_ZERO = 2'b01,
        SRC_REF  = 2'b10
    } src_e;

    localparam logic [2:0] CODE_IDLE = 3'b000;
    localparam logic [2:0] CODE_CONV = 3'b001;

endpackage

// File: rtl/cal_mode_decode.sv
module cal_mode_decode
    import adc_cal_pkg::*;
(
    input  logic [2:0] code,
    output logic       want_conv,
    output logic       want_cal,
    output logic       cal_gain,
    output logic       cal_system
);
    // Bit 2 marks calibration, bit 1 picks system over self,
    // bit 0 picks full-scale over zero-scale.
    always_comb begin
        want_conv  = (code == CODE_CONV);
        want_cal   = code[2];
        cal_gain   = code[0];
        cal_system = code[1];
    end
endmodule

// File: rtl/cal_period_counter.sv
module cal_period_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    assign hit = tick && !clr && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cal_coef_regs.sv
module cal_coef_regs #(
    parameter int          DW       = 16,
    parameter logic [DW-1:0] OFF_DEF  = '0,
    parameter logic [DW-1:0] GAIN_DEF = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_open,
    input  logic          sw_wr_off,
    input  logic          sw_wr_gain,
    input  logic [DW-1:0] sw_data,
    input  logic          hw_wr_off,
    input  logic          hw_wr_gain,
    input  logic [DW-1:0] hw_data,
    output logic [DW-1:0] offset_q,
    output logic [DW-1:0] gain_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q <= OFF_DEF;
        end else if (hw_wr_off) begin
            offset_q <= hw_data;
        end else if (sw_open && sw_wr_off) begin
            offset_q <= sw_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= GAIN_DEF;
        end else if (hw_wr_gain) begin
            gain_q <= hw_data;
        end else if (sw_open && sw_wr_gain) begin
            gain_q <= sw_data;
        end
    end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int            DW           = 16,
    parameter int            PER_CHOP_OFF = 3,
    parameter int            PER_CHOP_ON  = 2,
    parameter logic [DW-1:0] OFF_DEFAULT  = 16'h8000,
    parameter logic [DW-1:0] GAIN_DEFAULT = 16'h5555
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [2:0]    mode_wdata,
    input  logic          chop_en,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_result,
    input  logic          coef_wr_off,
    input  logic          coef_wr_gain,
    input  logic [DW-1:0] coef_wdata,
    output logic [2:0]    mode_q,
    output logic [1:0]    src_sel,
    output logic          busy,
    output logic          cal_done,
    output logic [DW-1:0] offset_q,
    output logic [DW-1:0] gain_q
);
    localparam int PER_MAX = (PER_CHOP_OFF > PER_CHOP_ON) ? PER_CHOP_OFF : PER_CHOP_ON;
    localparam int CNT_W   = $clog2(PER_MAX + 1);

    seq_state_e state, state_nx;

    logic          want_conv, want_cal, dec_gain, dec_system;
    logic          cal_sys_q, chop_q;
    logic [DW-1:0] lo_result_q;
    logic          in_cal, tick, hit;
    logic [CNT_W-1:0] limit;
    logic          hw_wr_off, hw_wr_gain;
    logic [DW-1:0] hw_data;

    cal_mode_decode u_dec (
        .code       (mode_wdata),
        .want_conv  (want_conv),
        .want_cal   (want_cal),
        .cal_gain   (dec_gain),
        .cal_system (dec_system)
    );

    assign in_cal = (state == ST_OFFSET) || (state == ST_GAIN_LO) || (state == ST_GAIN_HI);
    assign tick   = conv_done && in_cal;
    assign limit  = chop_q ? CNT_W'(PER_CHOP_ON) : CNT_W'(PER_CHOP_OFF);

    cal_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_wr),
        .tick  (tick),
        .limit (limit),
        .hit   (hit)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (mode_wr) begin
            if (want_cal) begin
                state_nx = dec_gain ? ST_GAIN_LO : ST_OFFSET;
            end else if (want_conv) begin
                state_nx = ST_CONV;
            end else begin
                state_nx = ST_IDLE;
            end
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_CONV:    state_nx = ST_CONV;
                ST_OFFSET:  if (hit) state_nx = ST_IDLE;
                ST_GAIN_LO: if (hit) state_nx = ST_GAIN_HI;
                ST_GAIN_HI: if (hit) state_nx = ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Registered outputs and cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_done    <= 1'b0;
            cal_sys_q   <= 1'b0;
            chop_q      <= 1'b0;
            lo_result_q <= '0;
        end else begin
            cal_done <= hw_wr_off || hw_wr_gain;
            if (mode_wr && want_cal) begin
                cal_sys_q <= dec_system;
                chop_q    <= chop_en;
            end
            if (state == ST_GAIN_LO && hit) begin
                lo_result_q <= conv_result;
            end
        end
    end

    assign hw_wr_off  = (state == ST_OFFSET)  && hit;
    assign hw_wr_gain = (state == ST_GAIN_HI) && hit;
    assign hw_data    = hw_wr_gain ? (conv_result - lo_result_q) : conv_result;

    // Decoded outputs
    always_comb begin
        busy    = in_cal;
        mode_q  = CODE_IDLE;
        src_sel = SRC_EXT;
        unique case (state)
            ST_IDLE: begin
                mode_q = CODE_IDLE;
            end
            ST_CONV: begin
                mode_q = CODE_CONV;
            end
            ST_OFFSET: begin
                mode_q  = {1'b1, cal_sys_q, 1'b0};
                src_sel = cal_sys_q ? SRC_EXT : SRC_ZERO;
            end
            ST_GAIN_LO: begin
                mode_q  = {1'b1, cal_sys_q, 1'b1};
                src_sel = cal_sys_q ? SRC_EXT : SRC_ZERO;
            end
            ST_GAIN_HI: begin
                mode_q  = {1'b1, cal_sys_q, 1'b1};
                src_sel = cal_sys_q ? SRC_EXT : SRC_REF;
            end
            default: begin
                mode_q = CODE_IDLE;
            end
        endcase
    end

    cal_coef_regs #(
        .DW       (DW),
        .OFF_DEF  (OFF_DEFAULT),
        .GAIN_DEF (GAIN_DEFAULT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_open    (state == ST_IDLE),
        .sw_wr_off  (coef_wr_off),
        .sw_wr_gain (coef_wr_gain),
        .sw_data    (coef_wdata),
        .hw_wr_off  (hw_wr_off),
        .hw_wr_gain (hw_wr_gain),
        .hw_data    (hw_data),
        .offset_q   (offset_q),
        .gain_q     (gain_q)
    );
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    mode_q,
    input logic [1:0]    src_sel,
    input logic          busy,
    input logic          cal_done,
    input logic [DW-1:0] offset_q,
    input logic [DW-1:0] gain_q
);
    a_r6_done_lands_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (mode_q == 3'b000 && !busy));

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    a_r7_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> $past(busy));

    a_r7_busy_in_cal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mode_q[2]);

    a_r2_unused_codes_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[2:1] != 2'b01);

    a_r9_conv_uses_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'b001) |-> (src_sel == 2'b00));

    a_r9_src_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel != 2'b11);

    a_r10_offset_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 3'b000) |=> ($stable(offset_q) || cal_done));

    a_r10_gain_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 3'b000) |=> ($stable(gain_q) || cal_done));
endmodule

bind adc_cal_seq adc_cal_seq_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .src_sel  (src_sel),
    .busy     (busy),
    .cal_done (cal_done),
    .offset_q (offset_q),
    .gain_q   (gain_q)
);

// File: tb/tb_adc_cal_seq.sv
`timescale 1ns/1ps
module tb_adc_cal_seq;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr = 1'b0;
    logic [2:0]    mode_wdata = '0;
    logic          chop_en = 1'b0;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_result = '0;
    logic          coef_wr_off = 1'b0;
    logic          coef_wr_gain = 1'b0;
    logic [DW-1:0] coef_wdata = '0;
    logic [2:0]    mode_q;
    logic [1:0]    src_sel;
    logic          busy;
    logic          cal_done;
    logic [DW-1:0] offset_q;
    logic [DW-1:0] gain_q;

    int n_vec = 0;
    int n_bad = 0;
    bit ended = 0;

    typedef struct {
        bit            is_gain;
        logic [DW-1:0] val;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    adc_cal_seq dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .chop_en(chop_en), .conv_done(conv_done), .conv_result(conv_result),
        .coef_wr_off(coef_wr_off), .coef_wr_gain(coef_wr_gain), .coef_wdata(coef_wdata),
        .mode_q(mode_q), .src_sel(src_sel), .busy(busy), .cal_done(cal_done),
        .offset_q(offset_q), .gain_q(gain_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic wr_mode(input logic [2:0] code);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = code;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic strobe(input logic [DW-1:0] val);
        @(negedge clk); conv_done = 1'b1; conv_result = val;
        @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic sw_coef(input bit off, input bit gn, input logic [DW-1:0] d);
        @(negedge clk); coef_wr_off = off; coef_wr_gain = gn; coef_wdata = d;
        @(negedge clk); coef_wr_off = 1'b0; coef_wr_gain = 1'b0;
    endtask

    task automatic expect_item(input bit is_gain, input logic [DW-1:0] v);
        exp_t e;
        e.is_gain = is_gain;
        e.val = v;
        exp_q.push_back(e);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cal_done) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R11 unexpected cal_done: actual 1 expected 0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_gain) check("R4 gain coefficient", 32'(gain_q), 32'(e.val));
                else           check("R5 offset coefficient", 32'(offset_q), 32'(e.val));
                check("R6 mode idle at done", 32'(mode_q), 32'd0);
                check("R6 busy low at done", 32'(busy), 32'd0);
            end
        end
    end

    initial begin
        #1_000_000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] g_keep, o_keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 mode", 32'(mode_q), 32'd0);
        check("R1 offset", 32'(offset_q), 32'h8000);
        check("R1 gain", 32'(gain_q), 32'h5555);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(cal_done), 32'd0);
        check("R1 src", 32'(src_sel), 32'd0);

        // R10 idle write accepted
        sw_coef(1, 0, 16'h1234);
        check("R10 idle offset write", 32'(offset_q), 32'h1234);
        sw_coef(0, 1, 16'h4321);
        check("R10 idle gain write", 32'(gain_q), 32'h4321);

        // R2 conversion; R12 strobes ignored; R10 write ignored
        wr_mode(3'b001);
        check("R2 conv readback", 32'(mode_q), 32'd1);
        check("R9 conv source", 32'(src_sel), 32'd0);
        check("R7 conv not busy", 32'(busy), 32'd0);
        strobe(16'h0F0F);
        strobe(16'h0E0E);
        strobe(16'h0D0D);
        check("R12 offset unchanged", 32'(offset_q), 32'h1234);
        check("R12 gain unchanged", 32'(gain_q), 32'h4321);
        sw_coef(1, 1, 16'hBEEF);
        check("R10 conv offset write ignored", 32'(offset_q), 32'h1234);
        check("R10 conv gain write ignored", 32'(gain_q), 32'h4321);

        // R2 unused codes
        wr_mode(3'b010);
        check("R2 code 010 reads idle", 32'(mode_q), 32'd0);
        wr_mode(3'b001);
        wr_mode(3'b011);
        check("R2 code 011 reads idle", 32'(mode_q), 32'd0);
        check("R2 code 011 not busy", 32'(busy), 32'd0);

        // R3 R5 R8: self zero-scale from conversion, chop off
        wr_mode(3'b001);
        chop_en = 1'b0;
        wr_mode(3'b100);
        check("R2 self zs readback", 32'(mode_q), 32'b100);
        check("R7 busy at start", 32'(busy), 32'd1);
        check("R9 self zs source", 32'(src_sel), 32'd1);
        strobe(16'h0011);
        strobe(16'h0022);
        check("R3 still busy after 2 (chop off)", 32'(busy), 32'd1);
        check("R10 gain held during cal", 32'(gain_q), 32'h4321);
        expect_item(0, 16'h0033);
        strobe(16'h0033);
        check("R5 offset loaded", 32'(offset_q), 32'h0033);
        check("R5 gain untouched", 32'(gain_q), 32'h4321);
        check("R6 done pulse", 32'(cal_done), 32'd1);
        check("R2 mode back idle", 32'(mode_q), 32'd0);
        @(negedge clk);
        check("R6 done one cycle", 32'(cal_done), 32'd0);

        // R4 R9: self full-scale, chop on
        chop_en = 1'b1;
        wr_mode(3'b101);
        check("R9 self fs stage1 source", 32'(src_sel), 32'd1);
        strobe(16'h0100);
        strobe(16'h0110);
        check("R9 self fs stage2 source", 32'(src_sel), 32'd2);
        check("R4 busy between stages", 32'(busy), 32'd1);
        strobe(16'h7000);
        check("R4 still busy in stage 2", 32'(busy), 32'd1);
        expect_item(1, 16'h70F0);
        strobe(16'h7200);
        check("R9 source back external", 32'(src_sel), 32'd0);
        check("R4 gain span", 32'(gain_q), 32'h70F0);

        // R9 system zero-scale, chop on
        wr_mode(3'b110);
        check("R9 system zs source", 32'(src_sel), 32'd0);
        check("R2 system zs readback", 32'(mode_q), 32'b110);
        strobe(16'h0041);
        expect_item(0, 16'h0042);
        strobe(16'h0042);
        check("R3 chop on two periods", 32'(offset_q), 32'h0042);

        // R4 system full-scale, chop off: 6 strobes
        chop_en = 1'b0;
        wr_mode(3'b111);
        strobe(16'h0001);
        strobe(16'h0002);
        strobe(16'h0010);
        check("R4 busy after stage 1", 32'(busy), 32'd1);
        check("R9 system fs stage2 source", 32'(src_sel), 32'd0);
        check("R2 system fs readback", 32'(mode_q), 32'b111);
        strobe(16'h1000);
        strobe(16'h2000);
        expect_item(1, 16'h6000);
        strobe(16'h6010);
        check("R4 system gain", 32'(gain_q), 32'h6000);

        // R8 restart
        wr_mode(3'b100);
        strobe(16'h0AAA);
        strobe(16'h0BBB);
        wr_mode(3'b100);
        strobe(16'h0CCC);
        strobe(16'h0DDD);
        check("R8 restart needs full count", 32'(busy), 32'd1);
        check("R8 offset not yet written", 32'(offset_q), 32'h0042);
        expect_item(0, 16'h0EEE);
        strobe(16'h0EEE);
        check("R8 restarted capture", 32'(offset_q), 32'h0EEE);

        // R11 abandon
        wr_mode(3'b110);
        strobe(16'h1111);
        wr_mode(3'b000);
        check("R11 mode idle after abandon", 32'(mode_q), 32'd0);
        check("R11 busy low after abandon", 32'(busy), 32'd0);
        strobe(16'h2222);
        strobe(16'h3333);
        check("R11 no capture", 32'(offset_q), 32'h0EEE);
        wr_mode(3'b101);
        strobe(16'h4444);
        wr_mode(3'b001);
        strobe(16'h5555);
        strobe(16'h6666);
        check("R11 gain not captured", 32'(gain_q), 32'h6000);

        // R10 writes during cal; R3 chop latched at start
        wr_mode(3'b100);
        o_keep = offset_q;
        g_keep = gain_q;
        sw_coef(1, 1, 16'hAAAA);
        check("R10 cal offset write ignored", 32'(offset_q), 32'(o_keep));
        check("R10 cal gain write ignored", 32'(gain_q), 32'(g_keep));
        chop_en = 1'b1;
        strobe(16'h0101);
        strobe(16'h0202);
        check("R3 chop change ignored mid-cycle", 32'(busy), 32'd1);
        expect_item(0, 16'h0303);
        strobe(16'h0303);
        check("R3 capture after three", 32'(offset_q), 32'h0303);

        repeat (3) @(negedge clk);
        check("R6 every expected done seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule